// File: doc/BRIEF.md
# Dual-Channel Double-Rate Sample Deserializer

This block receives the already-buffered, single-ended output bus of a two-channel 16-bit sampling converter and turns it back into parallel samples. Each channel arrives on eight lanes. Each lane carries two bits in every period of the forwarded clock: an even-numbered bit while the clock is low and the next odd-numbered bit while it is high. One extra lane carries both channels' out-of-range flags, split by clock phase in the same way.

The forwarded clock is assumed to be phase-shifted so that both of its edges fall inside the data-valid window. The low-phase half is captured on the rising edge that ends it, and the high-phase half is captured on the falling edge that ends it. Both halves are then moved into one rising-edge domain and interleaved into full words. The two words, their flags and a valid strobe leave together in a single register stage. While the lanes keep running, the block delivers one sample pair per clock.

Top module: `ddr_sample_deser`

## Requirements
- R1: Lane k of a channel supplies word bit 2k from its low phase and word bit 2k+1 from its high phase, for k = 0..7. This rebuilds one 16-bit word per channel.
- R2: The low-phase half is sampled on the rising clock edge that ends the low phase. The high-phase half is sampled on the falling edge that ends the high phase.
- R3: The flag lane's low-phase value becomes the channel B flag and its high-phase value becomes the channel A flag. A flag is 1 when that channel's sample was out of range.
- R4: A sample whose low phase ends at rising edge N appears on the outputs right after rising edge N+2. Its words and both flags appear in the same cycle.
- R5: While the synchronous, active-high reset is sampled high on a rising edge, both words, both flags and the valid strobe are 0 after that edge.
- R6: After reset is released, valid stays 0 after the first and second rising edges and is 1 from the third. It then stays 1 for every clock while the lanes keep delivering samples.
- R7: While valid is 0, both words and both flags read 0.
- R8: Capture is correct for any data-to-clock offset that keeps both clock edges inside the data window. This includes offsets near either end of the half-period.
- R9: The two channels are independent. Any bit pattern on one channel leaves the other channel's word and flag unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fwd_i | input | 1 | Forwarded clock, already phase-shifted into the data window |
| rst_i | input | 1 | Synchronous active-high reset (rising edge) |
| lane_a_i | input | 8 | Channel A lanes; lane k carries bits 2k (low) and 2k+1 (high) |
| lane_b_i | input | 8 | Channel B lanes; same mapping as channel A |
| ovf_lane_i | input | 1 | Shared flag lane: channel B while low, channel A while high |
| smp_a_o | output | 16 | Rebuilt channel A word |
| smp_b_o | output | 16 | Rebuilt channel B word |
| ovf_a_o | output | 1 | Channel A out-of-range flag |
| ovf_b_o | output | 1 | Channel B out-of-range flag |
| vld_o | output | 1 | High while the outputs hold an assembled sample pair |

## Verification
A swapped or shifted capture register shows up at the ports within three clocks of the sample concerned. It appears as a word whose bit pairs are exchanged, a flag on the wrong channel, or a word that belongs to the neighbouring sample. Walking-one patterns make each lane and phase individually visible. A fault in the fill tracker shows up as valid rising one edge early or late after reset, or as valid dropping during a continuous stream. Each word is compared against a queue of driven samples in strict order, so any change in latency appears as an ordering mismatch on the first valid output.

// File: rtl/ddr_deser_pkg.sv
package ddr_deser_pkg;

   // Pipeline fill progress after reset release
   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,   // nothing captured yet
      FS_EVEN = 2'd1,   // low-phase half captured
      FS_PAIR = 2'd2,   // both halves aligned
      FS_LIVE = 2'd3    // outputs carry valid data
   } fill_e;

   localparam int unsigned BITS_PER_LANE = 2;

endpackage

// File: rtl/ddr_edge_capture.sv
module ddr_edge_capture #(
   parameter int unsigned W = 8
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] rise_q_o,
   output logic [W-1:0] fall_q_o
);

   generate
      if (W < 1) begin : g_bad_w
         $error("ddr_edge_capture: W must be at least 1");
      end
   endgenerate

   // low-phase half, captured as the low phase closes
   always_ff @(posedge clk_i) begin
      if (rst_i) rise_q_o <= '0;
      else       rise_q_o <= d_i;
   end

   // high-phase half, captured as the high phase closes; downstream reset covers it
   always_ff @(negedge clk_i) begin
      fall_q_o <= d_i;
   end

endmodule

// File: rtl/ddr_phase_align.sv
module ddr_phase_align #(
   parameter int unsigned W = 8
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [W-1:0] rise_q_i,
   input  logic [W-1:0] fall_q_i,
   output logic [W-1:0] lo_o,
   output logic [W-1:0] hi_o
);

   generate
      if (W < 1) begin : g_bad_w
         $error("ddr_phase_align: W must be at least 1");
      end
   endgenerate

   // rise_q_i still holds the half captured one edge earlier; fall_q_i the half in between
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         lo_o <= '0;
         hi_o <= '0;
      end else begin
         lo_o <= rise_q_i;
         hi_o <= fall_q_i;
      end
   end

endmodule

// File: rtl/ddr_fill_tracker.sv
module ddr_fill_tracker
   import ddr_deser_pkg::*;
(
   input  logic clk_i,
   input  logic rst_i,
   output logic load_en_o,
   output logic vld_o
);

   fill_e state_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= FS_IDLE;
      end else begin
         unique case (state_q)
            FS_IDLE: state_q <= FS_EVEN;
            FS_EVEN: state_q <= FS_PAIR;
            FS_PAIR: state_q <= FS_LIVE;
            default: state_q <= FS_LIVE;
         endcase
      end
   end

   assign load_en_o = (state_q == FS_PAIR) || (state_q == FS_LIVE);

   always_ff @(posedge clk_i) begin
      if (rst_i) vld_o <= 1'b0;
      else       vld_o <= load_en_o;
   end

   // R6
   live_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == FS_LIVE) |=> (state_q == FS_LIVE));

endmodule

// File: rtl/ddr_word_assemble.sv
module ddr_word_assemble #(
   parameter int unsigned LANES = 8,
   localparam int unsigned WORD_W = 2 * LANES
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              load_en_i,
   input  logic [LANES-1:0]  lo_i,
   input  logic [LANES-1:0]  hi_i,
   input  logic              flag_i,
   output logic [WORD_W-1:0] word_o,
   output logic              flag_o
);

   logic [WORD_W-1:0] woven;

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("ddr_word_assemble: LANES must be at least 1");
      end
      for (genvar k = 0; k < LANES; k++) begin : g_weave
         assign woven[2*k]   = lo_i[k];
         assign woven[2*k+1] = hi_i[k];
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         word_o <= '0;
         flag_o <= 1'b0;
      end else if (load_en_i) begin
         word_o <= woven;
         flag_o <= flag_i;
      end
   end

   // R7
   hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !load_en_i |=> ($stable(word_o) && $stable(flag_o)));

endmodule

// File: rtl/ddr_sample_deser.sv
module ddr_sample_deser
   import ddr_deser_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 16,
   localparam int unsigned LANES = SAMPLE_W / BITS_PER_LANE
) (
   input  logic                clk_fwd_i,
   input  logic                rst_i,
   input  logic [LANES-1:0]    lane_a_i,
   input  logic [LANES-1:0]    lane_b_i,
   input  logic                ovf_lane_i,
   output logic [SAMPLE_W-1:0] smp_a_o,
   output logic [SAMPLE_W-1:0] smp_b_o,
   output logic                ovf_a_o,
   output logic                ovf_b_o,
   output logic                vld_o
);

   generate
      if ((SAMPLE_W % BITS_PER_LANE) != 0 || SAMPLE_W < 2) begin : g_bad_w
         $error("ddr_sample_deser: SAMPLE_W must be even and at least 2");
      end
   endgenerate

   localparam int unsigned CAP_W = 2 * LANES + 1;

   logic [CAP_W-1:0] cap_d, rise_q, fall_q, lo_q, hi_q;
   logic             load_en;

   // bundle both channels and the flag lane into one capture word
   assign cap_d = {ovf_lane_i, lane_b_i, lane_a_i};

   ddr_edge_capture #(.W(CAP_W)) u_cap (
      .clk_i    (clk_fwd_i),
      .rst_i    (rst_i),
      .d_i      (cap_d),
      .rise_q_o (rise_q),
      .fall_q_o (fall_q)
   );

   ddr_phase_align #(.W(CAP_W)) u_align (
      .clk_i    (clk_fwd_i),
      .rst_i    (rst_i),
      .rise_q_i (rise_q),
      .fall_q_i (fall_q),
      .lo_o     (lo_q),
      .hi_o     (hi_q)
   );

   ddr_fill_tracker u_fill (
      .clk_i     (clk_fwd_i),
      .rst_i     (rst_i),
      .load_en_o (load_en),
      .vld_o     (vld_o)
   );

   // channel A flag rides the high phase
   ddr_word_assemble #(.LANES(LANES)) u_asm_a (
      .clk_i     (clk_fwd_i),
      .rst_i     (rst_i),
      .load_en_i (load_en),
      .lo_i      (lo_q[LANES-1:0]),
      .hi_i      (hi_q[LANES-1:0]),
      .flag_i    (hi_q[CAP_W-1]),
      .word_o    (smp_a_o),
      .flag_o    (ovf_a_o)
   );

   // channel B flag rides the low phase
   ddr_word_assemble #(.LANES(LANES)) u_asm_b (
      .clk_i     (clk_fwd_i),
      .rst_i     (rst_i),
      .load_en_i (load_en),
      .lo_i      (lo_q[2*LANES-1:LANES]),
      .hi_i      (hi_q[2*LANES-1:LANES]),
      .flag_i    (lo_q[CAP_W-1]),
      .word_o    (smp_b_o),
      .flag_o    (ovf_b_o)
   );

   // R5
   reset_clears_chk: assert property (@(posedge clk_fwd_i)
      rst_i |=> (!vld_o && smp_a_o == '0 && smp_b_o == '0 && !ovf_a_o && !ovf_b_o));

   // R6
   valid_latency_chk: assert property (@(posedge clk_fwd_i) disable iff (rst_i)
      $rose(vld_o) |-> ($past(!rst_i, 1) && $past(!rst_i, 2) && $past(!rst_i, 3)));

   // R7
   quiet_when_invalid_chk: assert property (@(posedge clk_fwd_i) disable iff (rst_i)
      !vld_o |-> (smp_a_o == '0 && smp_b_o == '0 && !ovf_a_o && !ovf_b_o));

endmodule

// File: tb/ddr_sample_deser_tb.sv
`timescale 1ns/1ps
module ddr_sample_deser_tb;

   localparam int W = 16;
   localparam int L = W / 2;
   localparam int E = 2 * W + 2;   // {ovf_a, ovf_b, a, b}

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [L-1:0] lane_a = '0, lane_b = '0;
   logic         ovf_lane = 1'b0;
   logic [W-1:0] smp_a, smp_b;
   logic         ovf_a, ovf_b, vld;

   int     n_chk = 0, n_bad = 0, since = 0;
   bit     rst_req = 1'b1, done = 1'b0;
   realtime off_ns = 1.0;
   string  tag = "R5";
   logic [E-1:0] stim_q[$];
   logic [E-1:0] exp_q[$];

   always #2 clk = ~clk;   // 250 MHz

   ddr_sample_deser u_dut (
      .clk_fwd_i (clk), .rst_i (rst), .lane_a_i (lane_a), .lane_b_i (lane_b),
      .ovf_lane_i (ovf_lane), .smp_a_o (smp_a), .smp_b_o (smp_b),
      .ovf_a_o (ovf_a), .ovf_b_o (ovf_b), .vld_o (vld)
   );

   task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // Driver: even bits and channel B flag in the low phase, odd bits and channel A flag in the high phase
   initial begin
      forever begin
         logic [E-1:0] s;
         @(negedge clk);
         rst = rst_req;
         if (rst_req) begin
            exp_q.delete();
            lane_a = '0; lane_b = '0; ovf_lane = 1'b0;
         end else begin
            if (stim_q.size() > 0) s = stim_q.pop_front();
            else s = {$urandom, $urandom};
            exp_q.push_back(s);
            #(off_ns);
            for (int k = 0; k < L; k++) begin
               lane_b[k] = s[2*k];
               lane_a[k] = s[W+2*k];
            end
            ovf_lane = s[E-2];
            @(posedge clk);
            #(off_ns);
            for (int k = 0; k < L; k++) begin
               lane_b[k] = s[2*k+1];
               lane_a[k] = s[W+2*k+1];
            end
            ovf_lane = s[E-1];
         end
      end
   end

   // Monitor: sample 1 ns after each rising edge
   always @(posedge clk) begin
      logic r;
      logic [E-1:0] e;
      r = rst;
      #1;
      if (r) begin
         since = 0;
         // R5: outputs cleared while reset is held
         chk(!vld && smp_a == '0 && smp_b == '0 && !ovf_a && !ovf_b, "R5 reset state",
             {29'd0, vld, ovf_a, ovf_b, smp_a, smp_b}, 64'd0);
      end else begin
         since++;
         if (since < 3) begin
            // R6 and R7: quiet during fill
            chk(!vld, "R6 valid during fill", {63'd0, vld}, 64'd0);
            chk(smp_a == '0 && smp_b == '0 && !ovf_a && !ovf_b, "R7 outputs while invalid",
                {30'd0, ovf_a, ovf_b, smp_a, smp_b}, 64'd0);
         end else begin
            // R4 and R6: valid from the third edge and continuous
            chk(vld, "R4 R6 valid after fill", {63'd0, vld}, 64'd1);
            if (vld) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R4 output without a driven sample", 64'd1, 64'd0);
               end else begin
                  e = exp_q.pop_front();
                  chk(smp_a == e[2*W-1:W], "R1 channel A word", 64'(smp_a), 64'(e[2*W-1:W]));
                  chk(smp_b == e[W-1:0],   "R1 channel B word", 64'(smp_b), 64'(e[W-1:0]));
                  chk(ovf_a == e[E-1],     "R3 channel A flag", 64'(ovf_a), 64'(e[E-1]));
                  chk(ovf_b == e[E-2],     "R3 channel B flag", 64'(ovf_b), 64'(e[E-2]));
               end
            end
         end
      end
   end

   task automatic drain();
      while (stim_q.size() > 0) @(negedge clk);
      repeat (5) @(negedge clk);
   endtask

   // R5: reset state at time zero, then release
   task automatic t_reset_state();
      tag = "R5";
      repeat (4) @(negedge clk);
      rst_req = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   // R2/R8: random streams at several data-to-clock offsets
   task automatic t_offsets();
      realtime offs[3] = '{0.4, 1.0, 1.6};
      foreach (offs[i]) begin
         tag = "R2 R8";
         off_ns = offs[i];
         for (int n = 0; n < 40; n++) stim_q.push_back({$urandom, $urandom});
         drain();
      end
      off_ns = 1.0;
   endtask

   // R1/R9: walking one on A against walking zero on B exposes each lane and phase
   task automatic t_walking();
      tag = "R1 R9";
      for (int i = 0; i < W; i++) begin
         logic [W-1:0] one;
         one = W'(1) << i;
         stim_q.push_back({2'b00, one, ~one});
      end
      stim_q.push_back({2'b00, {W{1'b1}}, {W{1'b0}}});
      stim_q.push_back({2'b00, {W{1'b0}}, {W{1'b1}}});
      drain();
   endtask

   // R3: all four flag combinations with fixed data
   task automatic t_flags();
      tag = "R3";
      for (int f = 0; f < 4; f++) stim_q.push_back({f[1:0], 16'h5A5A, 16'hA5A5});
      drain();
   endtask

   // R5/R6/R7: reset in mid-stream discards in-flight samples and refills
   task automatic t_mid_reset();
      tag = "R5 R6 R7";
      for (int n = 0; n < 6; n++) stim_q.push_back({$urandom, $urandom});
      repeat (3) @(negedge clk);
      rst_req = 1'b1;
      repeat (3) @(negedge clk);
      rst_req = 1'b0;
      stim_q.delete();
      repeat (8) @(negedge clk);
   endtask

   initial begin
      t_reset_state();
      t_walking();
      t_flags();
      t_offsets();
      t_mid_reset();
      t_offsets();
      done = 1'b1;
      finish_run();
   end

   initial begin
      #(4ns * 20000);
      if (!done) begin
         tag = "watchdog";
         chk(1'b0, "run did not finish", 64'd0, 64'd1);
         finish_run();
      end
   end

endmodule